// File: doc/BRIEF.md
# Dual-Channel Reload Pulse Generator

This block produces rectangular pulse trains from two 8-bit reload down-counters. Each counter has its own pair of reload values, one for the time the output stays low and one for the time it stays high. A counter starts in the low phase. Each time it reaches zero it reloads the value for the other phase and flips its output. The two counters can run on their own, be joined into one 16-bit counter, or be chained so that the first counter divides the count clock for the second.

Both counters step on a shared count tick. That tick is taken from the system clock divided by a power of two from 1 to 16, or from an external slow time-base pulse. Software-side logic writes the four reload registers through a simple write port. It then sets the mode, the clock-select code and the channel enables.

Top module: `ppg_pair`

## Requirements
- R1: Clock-select codes 0 to 4 give one count tick every 2^code system clocks. A reload value N then gives a phase of (N+1)*2^code clocks.
- R2: Clock-select code 5 uses each cycle on which `ext_tick` is high as a count tick. Codes 6 and 7 behave as code 0.
- R3: Mode code 0 (and the spare code 3) runs the two channels independently. Channel i drives `pulse_out[i]` low for low_i+1 ticks and then high for high_i+1 ticks, repeating. Channel i is enabled by `en[i]`.
- R4: Register write addresses are: 0 = channel 0 low width, 1 = channel 0 high width, 2 = channel 1 low width, 3 = channel 1 high width. Each write is captured on the clock edge where `wr_en` is high.
- R5: Mode code 1 joins the pair into one 16-bit counter. Its low width is {ch1 low, ch0 low}+1 ticks and its high width is {ch1 high, ch0 high}+1 ticks. Both outputs carry the same waveform. Only `en[0]` enables the pair, and `en[1]` is ignored.
- R6: Mode code 2 turns channel 0 into a prescaler that emits one pulse every ch0_low+1 ticks. Channel 1 counts those pulses, so its phase widths are (low_1+1)*(ch0_low+1) ticks and (high_1+1)*(ch0_low+1) ticks. `pulse_out[0]` stays low, only `en[0]` enables the pair, and `en[1]` is ignored.
- R7: A write to a reload register does not change the phase already running. The new value applies from the next reload of that register's phase.
- R8: While a channel is disabled, its output is low in the same cycle, and its counter holds its low reload value. After it is enabled with clock-select code 0, the first rising edge appears after exactly low+1 clocks.
- R9: Synchronous reset clears all reload registers to 0 and holds the outputs low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_tick | input | 1 | External time-base pulse, one clock wide |
| clk_sel | input | 3 | Count-clock select code |
| mode | input | 2 | Pair mode: 0 split, 1 joined 16-bit, 2 prescaled, 3 as 0 |
| en | input | 2 | Per-channel enable |
| wr_en | input | 1 | Reload register write strobe |
| wr_addr | input | 2 | Reload register address |
| wr_data | input | 8 | Reload register write data |
| pulse_out | output | 2 | Pulse outputs, one per channel |

## Verification
A counter that loads the wrong reload value, or that misses or doubles a tick, shows up directly as a wrong edge-to-edge distance on the output pins. The error appears within one full low-plus-high period. A broken borrow between the two halves in the joined mode only shows once the low byte wraps, so the joined test uses a low width above 255. Phase-register errors after a disable, or writes that land mid-phase, show up on the first edge after the event, so each of these events is followed by an exact edge-timing measurement.

// File: rtl/ppg_pkg.sv
`timescale 1ns/1ps
package ppg_pkg;
    localparam int PPG_CW      = 8;
    localparam int PPG_NCH     = 2;
    localparam int PPG_AW      = $clog2(PPG_NCH) + 1;
    localparam int PPG_DIV_LOG = 4;
    localparam int PPG_SEL_W   = 3;
    localparam logic [PPG_SEL_W-1:0] SEL_EXT = 3'd5;

    typedef enum logic [1:0] {
        PPG_SPLIT    = 2'd0,
        PPG_FUSED    = 2'd1,
        PPG_PRESCALE = 2'd2
    } ppg_mode_e;

    typedef struct packed {
        logic [PPG_CW-1:0] hi;
        logic [PPG_CW-1:0] lo;
    } ppg_reload_t;

    function automatic ppg_mode_e ppg_decode_mode(input logic [1:0] m);
        case (m)
            2'd1:    return PPG_FUSED;
            2'd2:    return PPG_PRESCALE;
            default: return PPG_SPLIT;
        endcase
    endfunction

    function automatic logic [PPG_SEL_W-1:0] ppg_norm_sel(input logic [PPG_SEL_W-1:0] s);
        return (s > SEL_EXT) ? '0 : s;
    endfunction
endpackage

// File: rtl/ppg_tick_gen.sv
`timescale 1ns/1ps
module ppg_tick_gen
    import ppg_pkg::*;
#(
    parameter int DIV_LOG = PPG_DIV_LOG
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ext_tick,
    input  logic [PPG_SEL_W-1:0] clk_sel,
    output logic                 tick
);
    logic [DIV_LOG-1:0]   div_cnt;
    logic [DIV_LOG-1:0]   mask;
    logic [PPG_SEL_W-1:0] sel;

    always_ff @(posedge clk) begin
        if (rst) div_cnt <= '0;
        else     div_cnt <= div_cnt + 1'b1;
    end

    always_comb begin
        sel  = ppg_norm_sel(clk_sel);
        mask = '0;
        for (int b = 0; b < DIV_LOG; b++) begin
            if (b < int'(sel)) mask[b] = 1'b1;
        end
        if (sel == SEL_EXT) tick = ext_tick;
        else                tick = ((div_cnt & mask) == mask);
    end
endmodule

// File: rtl/ppg_reload_bank.sv
`timescale 1ns/1ps
module ppg_reload_bank
    import ppg_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_en,
    input  logic [PPG_AW-1:0]               wr_addr,
    input  logic [PPG_CW-1:0]               wr_data,
    output ppg_reload_t [PPG_NCH-1:0]       rl
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rl <= '0;
        end else if (wr_en) begin
            for (int c = 0; c < PPG_NCH; c++) begin
                if (wr_addr[PPG_AW-1:1] == (PPG_AW-1)'(c)) begin
                    if (wr_addr[0]) rl[c].hi <= wr_data;
                    else            rl[c].lo <= wr_data;
                end
            end
        end
    end
endmodule

// File: rtl/ppg_down_cnt.sv
`timescale 1ns/1ps
module ppg_down_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (load) cnt <= load_val;
        else if (dec)  cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/ppg_pair.sv
`timescale 1ns/1ps
module ppg_pair
    import ppg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ext_tick,
    input  logic [PPG_SEL_W-1:0] clk_sel,
    input  logic [1:0]           mode,
    input  logic [PPG_NCH-1:0]   en,
    input  logic                 wr_en,
    input  logic [PPG_AW-1:0]    wr_addr,
    input  logic [PPG_CW-1:0]    wr_data,
    output logic [PPG_NCH-1:0]   pulse_out
);
    logic                             cnt_tick;
    ppg_reload_t [PPG_NCH-1:0]        rl;
    logic [PPG_NCH-1:0][PPG_CW-1:0]   cnt;
    logic [PPG_NCH-1:0][PPG_CW-1:0]   ld_val;
    logic [PPG_NCH-1:0]               ld, dec, zero;
    logic [PPG_NCH-1:0]               ph, ph_d;
    ppg_mode_e                        md;

    ppg_tick_gen u_tick (
        .clk(clk), .rst(rst), .ext_tick(ext_tick),
        .clk_sel(clk_sel), .tick(cnt_tick)
    );

    ppg_reload_bank u_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rl(rl)
    );

    for (genvar ch = 0; ch < PPG_NCH; ch++) begin : g_cnt
        ppg_down_cnt #(.W(PPG_CW)) u_cnt (
            .clk(clk), .rst(rst), .load(ld[ch]),
            .load_val(ld_val[ch]), .dec(dec[ch]), .cnt(cnt[ch])
        );
        assign zero[ch] = (cnt[ch] == '0);
    end

    assign md = ppg_decode_mode(mode);

    always_comb begin
        ld        = '0;
        dec       = '0;
        ld_val    = '0;
        ph_d      = ph;
        pulse_out = '0;
        case (md)
            PPG_FUSED: begin
                if (!en[0]) begin
                    ld     = '1;
                    ld_val = {rl[1].lo, rl[0].lo};
                    ph_d   = '0;
                end else if (cnt_tick) begin
                    if (&zero) begin
                        ld       = '1;
                        ld_val   = ph[0] ? {rl[1].lo, rl[0].lo} : {rl[1].hi, rl[0].hi};
                        ph_d[0]  = ~ph[0];
                    end else begin
                        dec[0] = 1'b1;
                        dec[1] = zero[0];
                    end
                end
                pulse_out = {PPG_NCH{ph[0] & en[0]}};
            end
            PPG_PRESCALE: begin
                if (!en[0]) begin
                    ld     = '1;
                    ld_val = {rl[1].lo, rl[0].lo};
                    ph_d   = '0;
                end else if (cnt_tick) begin
                    if (zero[0]) begin
                        ld[0]     = 1'b1;
                        ld_val[0] = rl[0].lo;
                        if (zero[1]) begin
                            ld[1]     = 1'b1;
                            ld_val[1] = ph[1] ? rl[1].lo : rl[1].hi;
                            ph_d[1]   = ~ph[1];
                        end else begin
                            dec[1] = 1'b1;
                        end
                    end else begin
                        dec[0] = 1'b1;
                    end
                end
                pulse_out[1] = ph[1] & en[0];
            end
            default: begin
                for (int i = 0; i < PPG_NCH; i++) begin
                    if (!en[i]) begin
                        ld[i]     = 1'b1;
                        ld_val[i] = rl[i].lo;
                        ph_d[i]   = 1'b0;
                    end else if (cnt_tick) begin
                        if (zero[i]) begin
                            ld[i]     = 1'b1;
                            ld_val[i] = ph[i] ? rl[i].lo : rl[i].hi;
                            ph_d[i]   = ~ph[i];
                        end else begin
                            dec[i] = 1'b1;
                        end
                    end
                    pulse_out[i] = ph[i] & en[i];
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ph <= '0;
        else     ph <= ph_d;
    end
endmodule

// File: rtl/ppg_pair_chk.sv
`timescale 1ns/1ps
module ppg_pair_chk
    import ppg_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 ext_tick,
    input logic [PPG_SEL_W-1:0] clk_sel,
    input logic [1:0]           mode,
    input logic [PPG_NCH-1:0]   en,
    input logic                 cnt_tick,
    input logic [PPG_NCH-1:0]   pulse_out
);
    ppg_mode_e md;
    assign md = ppg_decode_mode(mode);

    p_reset_low_r9: assert property (@(posedge clk) rst |=> (pulse_out == '0));

    p_sel0_every_clk_r1: assert property (@(posedge clk) disable iff (rst)
        (ppg_norm_sel(clk_sel) == '0) |-> cnt_tick);

    p_ext_source_r2: assert property (@(posedge clk) disable iff (rst)
        (clk_sel == SEL_EXT) |-> (cnt_tick == ext_tick));

    p_off_low_r8: assert property (@(posedge clk) disable iff (rst)
        (md == PPG_SPLIT && !en[0]) |-> !pulse_out[0]);

    p_mirror_r5: assert property (@(posedge clk) disable iff (rst)
        (md == PPG_FUSED) |-> (pulse_out[0] == pulse_out[1]));

    p_prescaler_pin_low_r6: assert property (@(posedge clk) disable iff (rst)
        (md == PPG_PRESCALE) |-> !pulse_out[0]);

    p_edge_needs_tick_r3: assert property (@(posedge clk) disable iff (rst)
        (md == PPG_SPLIT && $stable(mode) && en[0] && $past(en[0]) && !$stable(pulse_out[0]))
        |-> $past(cnt_tick));
endmodule

bind ppg_pair ppg_pair_chk chk_i (
    .clk(clk), .rst(rst), .ext_tick(ext_tick), .clk_sel(clk_sel),
    .mode(mode), .en(en), .cnt_tick(cnt_tick), .pulse_out(pulse_out)
);

// File: tb/ppg_pair_tb_top.sv
`timescale 1ns/1ps
module ppg_pair_tb_top;
    import ppg_pkg::*;

    localparam int EXT_PERIOD = 10;
    localparam int NVEC       = 13;

    typedef struct packed {
        logic [1:0] mode;
        logic [2:0] sel;
        logic [1:0] en;
        logic [7:0] lo0;
        logic [7:0] hi0;
        logic [7:0] lo1;
        logic [7:0] hi1;
    } vec_t;

    localparam vec_t VEC [NVEC] = '{
        '{2'd0, 3'd0, 2'b11, 8'd3, 8'd5, 8'd7, 8'd2},
        '{2'd0, 3'd1, 2'b11, 8'd2, 8'd4, 8'd1, 8'd3},
        '{2'd0, 3'd2, 2'b11, 8'd1, 8'd3, 8'd4, 8'd0},
        '{2'd0, 3'd3, 2'b11, 8'd2, 8'd1, 8'd0, 8'd3},
        '{2'd0, 3'd4, 2'b11, 8'd1, 8'd2, 8'd2, 8'd1},
        '{2'd0, 3'd5, 2'b11, 8'd2, 8'd3, 8'd1, 8'd4},
        '{2'd0, 3'd6, 2'b11, 8'd6, 8'd1, 8'd3, 8'd5},
        '{2'd0, 3'd7, 2'b11, 8'd0, 8'd4, 8'd2, 8'd2},
        '{2'd1, 3'd0, 2'b01, 8'd2, 8'd48, 8'd1, 8'd0},
        '{2'd1, 3'd1, 2'b01, 8'd5, 8'd3, 8'd0, 8'd0},
        '{2'd2, 3'd0, 2'b01, 8'd3, 8'd9, 8'd2, 8'd4},
        '{2'd2, 3'd2, 2'b01, 8'd1, 8'd0, 8'd0, 8'd2},
        '{2'd3, 3'd0, 2'b11, 8'd4, 8'd2, 8'd1, 8'd6}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ext_tick = 1'b0;
    logic [2:0] clk_sel = '0;
    logic [1:0] mode = '0;
    logic [1:0] en = '0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] pulse_out;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    initial begin
        forever begin
            repeat (EXT_PERIOD - 1) @(negedge clk);
            ext_tick = 1'b1;
            @(negedge clk);
            ext_tick = 1'b0;
        end
    end

    ppg_pair dut_i (
        .clk(clk), .rst(rst), .ext_tick(ext_tick), .clk_sel(clk_sel),
        .mode(mode), .en(en), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pulse_out(pulse_out)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int tick_period(input logic [2:0] s);
        if (s <= 3'd4) return 1 << s;
        if (s == 3'd5) return EXT_PERIOD;
        return 1;
    endfunction

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic measure(input int ch, output int lo, output int hi);
        while (pulse_out[ch] !== 1'b0) @(negedge clk);
        while (pulse_out[ch] !== 1'b1) @(negedge clk);
        hi = 0;
        while (pulse_out[ch] === 1'b1) begin hi++; @(negedge clk); end
        lo = 0;
        while (pulse_out[ch] === 1'b0) begin lo++; @(negedge clk); end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int lo, hi, p, t, cnt0;
        // R9: outputs low while in reset even with enables high
        en = 2'b11;
        repeat (4) @(negedge clk);
        check("R9 reset output", int'(pulse_out), 0);
        rst = 1'b0;
        // R9: cleared reload registers give one-clock phases
        measure(0, lo, hi);
        check("R9 cleared low width", lo, 1);
        check("R9 cleared high width", hi, 1);
        en = 2'b00;
        @(negedge clk);

        for (int v = 0; v < NVEC; v++) begin
            en = 2'b00;
            mode = VEC[v].mode;
            clk_sel = VEC[v].sel;
            @(negedge clk);
            wr(2'd0, VEC[v].lo0);   // R4 address map
            wr(2'd1, VEC[v].hi0);
            wr(2'd2, VEC[v].lo1);
            wr(2'd3, VEC[v].hi1);
            en = VEC[v].en;
            t = tick_period(VEC[v].sel);
            case (VEC[v].mode)
                2'd1: begin
                    // R5 joined 16-bit widths on both pins
                    for (int ch = 0; ch < 2; ch++) begin
                        measure(ch, lo, hi);
                        check("R5 joined low width", lo, ({VEC[v].lo1, VEC[v].lo0} + 1) * t);
                        check("R5 joined high width", hi, ({VEC[v].hi1, VEC[v].hi0} + 1) * t);
                    end
                end
                2'd2: begin
                    // R6 prescaled channel 1, channel 0 pin idle
                    p = VEC[v].lo0 + 1;
                    measure(1, lo, hi);
                    check("R6 prescaled low width", lo, (VEC[v].lo1 + 1) * p * t);
                    check("R6 prescaled high width", hi, (VEC[v].hi1 + 1) * p * t);
                    cnt0 = 0;
                    for (int k = 0; k < 40; k++) begin
                        @(negedge clk);
                        if (pulse_out[0] !== 1'b0) cnt0++;
                    end
                    check("R6 prescaler pin high count", cnt0, 0);
                end
                default: begin
                    // R1 R2 R3 split widths per clock select
                    measure(0, lo, hi);
                    check("R1 R2 R3 ch0 low width", lo, (VEC[v].lo0 + 1) * t);
                    check("R1 R2 R3 ch0 high width", hi, (VEC[v].hi0 + 1) * t);
                    measure(1, lo, hi);
                    check("R1 R2 R3 ch1 low width", lo, (VEC[v].lo1 + 1) * t);
                    check("R1 R2 R3 ch1 high width", hi, (VEC[v].hi1 + 1) * t);
                end
            endcase
        end

        // R8: restart gives a fresh low phase of low+1 clocks
        en = 2'b00; mode = 2'd0; clk_sel = 3'd0;
        @(negedge clk);
        wr(2'd0, 8'd4);
        wr(2'd1, 8'd5);
        repeat (3) @(negedge clk);
        en = 2'b01;
        cnt0 = 0;
        do begin @(negedge clk); cnt0++; end while (pulse_out[0] !== 1'b1 && cnt0 < 100);
        check("R8 first rise after enable", cnt0, 5);

        // R8: disabling mid-high forces the pin low at once and holds it
        en = 2'b00;
        #1;
        check("R8 immediate low", int'(pulse_out[0]), 0);
        cnt0 = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (pulse_out[0] !== 1'b0) cnt0++;
        end
        check("R8 held low while off", cnt0, 0);

        // R7: reload write during a high phase applies at the next reload
        wr(2'd0, 8'd5);
        wr(2'd1, 8'd5);
        en = 2'b01;
        while (pulse_out[0] !== 1'b1) @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'd20;
        hi = 0;
        while (pulse_out[0] === 1'b1) begin hi++; @(negedge clk); wr_en = 1'b0; end
        check("R7 running high phase kept", hi, 6);
        lo = 0;
        while (pulse_out[0] === 1'b0) begin lo++; @(negedge clk); end
        check("R7 low phase", lo, 6);
        hi = 0;
        while (pulse_out[0] === 1'b1) begin hi++; @(negedge clk); end
        check("R7 next high uses new value", hi, 21);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule